// File: doc/BRIEF.md
# Prescaled Interval/Match Timer Channel

This block is a single 16-bit timer channel behind a simple word-indexed register port. Each count step comes from one of two sources: every bus clock cycle, or a selected edge of an external clock input that is first synchronised into the bus clock domain. An optional power-of-two prescaler can divide the step rate. The counter runs up or down. In overflow mode it wraps at the ends of its range. In interval mode it wraps at a programmable interval value.

The count is compared against three match values. The channel records interval, match and overflow events in sticky status flags, and reading the status register clears them. An interrupt line is raised while any flag is set whose enable bit is also set. A waveform output changes level on a match-0 event and goes back to its idle level on a wrap. Its polarity can be selected, and it has an active-low enable. A self-clearing restart bit reloads the count and restarts counting.

Top module: `pim_timer`

## Requirements
- R1: After reset, index 0 reads 0, index 1 reads 0x21 (counting halted, waveform disabled), the count reads 0, status reads 0, and both `wave_o` and `irq_o` are 0.
- R2: The word index on `bus_addr_i` selects a register:
  - 0: clock control
  - 1: counter control
  - 2: count (read-only; writes are ignored)
  - 3: interval
  - 4: match-0
  - 5: match-1
  - 6: match-2
  - 7: status
  - 8: interrupt enable

  The interval and match registers keep only bits 15:0 and read back zero above them.
- R3: Writing 1 to counter-control bit 4 applies a restart on the next clock. The restart loads the count with 0 when counting up, with the interval value when counting down in interval mode, and with 0xFFFF when counting down in overflow mode. It also clears the prescaler and returns the waveform to its idle level. Bit 4 then reads back 0, and counting resumes on the clock after.
- R4: Counter-control bit 0 set halts the count. When it is clear, with the bus clock selected (clock-control bit 5 = 0) and the prescaler off, the count moves one step every clock.
- R5: With clock-control bit 0 set, the count moves one step for every 2^(N+1) source edges, where N is clock-control bits 4:1.
- R6: In interval mode (counter-control bit 1 = 1), an up count at the interval value wraps to 0, and a down count at 0 reloads the interval value. Either wrap sets status bit 0.
- R7: In overflow mode, an up count wraps from 0xFFFF to 0 and a down count wraps from 0 to 0xFFFF. Either wrap sets status bit 4. Counter-control bit 2 selects down counting.
- R8: With counter-control bit 3 set, a step that lands the count on match value k (k = 0, 1, 2) sets status bit k+1. With bit 3 clear, no match bit is set.
- R9: Status flags are sticky. A read of index 7 returns them and then clears them. An event in the same cycle as the read stays set. Status bit 5 always reads 0.
- R10: `irq_o` is high exactly while some status bit and its bit in the interrupt-enable register (same bit layout) are both 1.
- R11: `wave_o` is 0 while counter-control bit 5 is 1. While bit 5 is 0:
  - with bit 6 = 0, the output idles high, goes low on a match-0 event and goes high again on a wrap;
  - with bit 6 = 1, these levels are inverted.

  When a wrap and a match-0 event occur in the same step, the wrap wins.
- R12: With clock-control bit 5 = 1, steps follow rising edges of `ext_clk_i` after a two-flop synchroniser. With clock-control bit 6 also set, steps follow falling edges instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (clears status on index 7) |
| bus_addr_i | input | 4 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt request |

## Verification
An error in the count register shows up the next time index 2 is read. It also shows up as a missing or extra wrap, which changes status bits 0 or 4 within one step period. If the prescaler phase drifts, the final count of a fixed-length run is off by one or more, so each run is timed exactly to the cycle and then halted before the count is read. A waveform state that is stuck or inverted, or a status flag that fails to clear or stays sticky, is visible at `wave_o`, `irq_o` or in the next status read. The read happens at most a few clocks after the event.

// File: rtl/pim_timer_pkg.sv
// Package: shared constants and control-word layouts of the timer channel.
// Assumes the control words are 7 bits wide and that status and enable use the same bit order.
package pim_timer_pkg;

    localparam int PRE_W  = 4;   // prescale exponent field width
    localparam int CFG_W  = 7;   // control word width
    localparam int NMATCH = 3;   // number of match comparators
    localparam int NEV    = 6;   // status / enable width

    // Event bit positions (status and enable share them)
    localparam int EV_INTV = 0;
    localparam int EV_M0   = 1;
    localparam int EV_OVF  = 4;
    localparam int EV_EXT  = 5;  // unused event slot, always 0

    // Register word indices
    localparam int REG_CLK   = 0;
    localparam int REG_CNT   = 1;
    localparam int REG_COUNT = 2;
    localparam int REG_INTV  = 3;
    localparam int REG_M0    = 4;
    localparam int REG_M1    = 5;
    localparam int REG_M2    = 6;
    localparam int REG_STAT  = 7;
    localparam int REG_IEN   = 8;

    typedef struct packed {
        logic             ext_fall;  // bit 6
        logic             src_ext;   // bit 5
        logic [PRE_W-1:0] pre_n;     // bits 4:1
        logic             pre_en;    // bit 0
    } clk_cfg_t;

    typedef struct packed {
        logic wave_pol;   // bit 6
        logic wave_dis;   // bit 5
        logic restart;    // bit 4
        logic match_en;   // bit 3
        logic down;       // bit 2
        logic intv_mode;  // bit 1
        logic halt;       // bit 0
    } cnt_cfg_t;

    localparam cnt_cfg_t CNT_CFG_RST = '{wave_pol: 1'b0, wave_dis: 1'b1, restart: 1'b0,
                                         match_en: 1'b0, down: 1'b0, intv_mode: 1'b0,
                                         halt: 1'b1};

endpackage

// File: rtl/pim_tick_gen.sv
// Step-pulse generator: picks the bus clock or a synchronised external edge and
// optionally divides it by 2^(N+1). Assumes ext_clk_i is asynchronous and slower
// than half the bus clock rate.
module pim_tick_gen
    import pim_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ext_clk_i,
    input  clk_cfg_t cfg_i,
    input  logic     run_i,
    input  logic     restart_i,
    output logic     tick_o
);
    localparam int DIV_W = 1 << PRE_W;

    logic             ext_s1, ext_s2, ext_s3;
    logic             src_edge;
    logic [DIV_W-1:0] pre_cnt;
    logic [DIV_W-1:0] pre_mask;
    logic             pre_last;

    // Two-flop synchroniser plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_s1 <= 1'b0;
            ext_s2 <= 1'b0;
            ext_s3 <= 1'b0;
        end else begin
            ext_s1 <= ext_clk_i;
            ext_s2 <= ext_s1;
            ext_s3 <= ext_s2;
        end
    end

    // Source edge: every cycle for the bus clock, else the selected external edge
    always_comb begin
        if (!cfg_i.src_ext)
            src_edge = 1'b1;
        else if (cfg_i.ext_fall)
            src_edge = ext_s3 & ~ext_s2;
        else
            src_edge = ext_s2 & ~ext_s3;
    end

    // Terminal mask: bits 0..N set, so the divider spans 2^(N+1) edges
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign pre_mask[i] = (PRE_W'(i) <= cfg_i.pre_n);
    end

    assign pre_last = (pre_cnt >= pre_mask);
    assign tick_o   = run_i & ~restart_i & src_edge & (~cfg_i.pre_en | pre_last);

    // Prescale counter: cleared by restart or when bypassed, advances on source edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (restart_i || !cfg_i.pre_en) begin
            pre_cnt <= '0;
        end else if (run_i && src_edge) begin
            pre_cnt <= pre_last ? '0 : pre_cnt + 1'b1;
        end
    end

    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && cfg_i.pre_en) |=> (!tick_o || !cfg_i.pre_en)); // R5

endmodule

// File: rtl/pim_count_core.sv
// Count core: 16-bit up/down counter with interval or overflow wrap, three match
// comparators, registered event pulses and the waveform level. Assumes tick_i is
// already gated by the run enable and suppressed during restart.
module pim_count_core
    import pim_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       restart_i,
    input  logic                       down_i,
    input  logic                       intv_mode_i,
    input  logic                       match_en_i,
    input  logic                       wave_dis_i,
    input  logic                       wave_pol_i,
    input  logic [CW-1:0]              intv_i,
    input  logic [NMATCH-1:0][CW-1:0]  match_i,
    output logic [CW-1:0]              cnt_o,
    output logic [NEV-1:0]             ev_o,
    output logic                       wave_o
);
    logic [CW-1:0]     cnt_q, cnt_nx, load_val;
    logic              wrap;
    logic [NMATCH-1:0] hit;
    logic [NEV-1:0]    ev_nx, ev_q;
    logic              wave_act;

    // Next count and wrap detection for the four direction/mode combinations
    always_comb begin
        if (!down_i) begin
            wrap   = intv_mode_i ? (cnt_q == intv_i) : (&cnt_q);
            cnt_nx = (intv_mode_i && wrap) ? '0 : cnt_q + 1'b1;
        end else begin
            wrap   = (cnt_q == '0);
            cnt_nx = (intv_mode_i && wrap) ? intv_i : cnt_q - 1'b1;
        end
    end

    // Restart load value: bottom when counting up, top when counting down
    assign load_val = !down_i ? '0 : (intv_mode_i ? intv_i : '1);

    // Match comparators against the value the count is about to take
    for (genvar k = 0; k < NMATCH; k++) begin : g_match
        assign hit[k] = match_en_i && (cnt_nx == match_i[k]);
    end

    // Event vector for one step
    always_comb begin
        ev_nx                    = '0;
        ev_nx[EV_INTV]           = wrap & intv_mode_i;
        ev_nx[EV_OVF]            = wrap & ~intv_mode_i;
        ev_nx[EV_M0 +: NMATCH]   = hit;
        ev_nx[EV_EXT]            = 1'b0;
    end

    // Counter and event pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ev_q  <= '0;
        end else if (restart_i) begin
            cnt_q <= load_val;
            ev_q  <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_nx;
            ev_q  <= ev_nx;
        end else begin
            ev_q  <= '0;
        end
    end

    // Waveform state: set by match-0, cleared by any wrap (wrap has priority)
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i)
            wave_act <= 1'b0;
        else if (ev_q[EV_INTV] || ev_q[EV_OVF])
            wave_act <= 1'b0;
        else if (ev_q[EV_M0])
            wave_act <= 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign ev_o   = ev_q;
    assign wave_o = wave_dis_i ? 1'b0 : (wave_act ^ ~wave_pol_i);

    AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !down_i) |=> (cnt_o == '0)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(cnt_o)); // R4
    AST_INTV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i && intv_mode_i && !down_i && cnt_o == intv_i)
        |=> (cnt_o == '0 && ev_o[EV_INTV])); // R6
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i && !intv_mode_i && !down_i && (&cnt_o))
        |=> (cnt_o == '0 && ev_o[EV_OVF])); // R7

endmodule

// File: rtl/pim_irq_ctrl.sv
// Status and interrupt: latches event pulses into sticky flags, clears them on a
// status read (new events win), and ORs the enabled flags into one request.
module pim_irq_ctrl
    import pim_timer_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev_i,
    input  logic           rd_clr_i,
    input  logic [NEV-1:0] ien_i,
    output logic [NEV-1:0] status_o,
    output logic           irq_o
);
    logic [NEV-1:0] status_q;

    // Sticky flag register with read-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (rd_clr_i ? '0 : status_q) | ev_i;
    end

    assign status_o = status_q;
    assign irq_o    = |(status_q & ien_i);

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && ev_i == '0) |=> (status_o == '0)); // R9

endmodule

// File: rtl/pim_timer.sv
// Timer channel top: register file and read mux around the step generator, count
// core and status logic. Assumes single-cycle register strobes and DW >= CW.
module pim_timer
    import pim_timer_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_clk_i,
    input  logic          bus_wr_i,
    input  logic          bus_rd_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          wave_o,
    output logic          irq_o
);
    clk_cfg_t                  clk_cfg_q;
    cnt_cfg_t                  cnt_cfg_q;
    logic [CW-1:0]             intv_q;
    logic [NMATCH-1:0][CW-1:0] match_q;
    logic [NEV-1:0]            ien_q;
    logic [NEV-1:0]            status;
    logic [NEV-1:0]            ev;
    logic [CW-1:0]             cnt;
    logic                      tick;
    logic                      rd_clr;
    logic                      wdata_unused;

    assign wdata_unused = &{1'b0, bus_wdata_i[DW-1:CW]};
    assign rd_clr       = bus_rd_i && (bus_addr_i == AW'(REG_STAT));

    // Register writes; the restart bit drops one cycle after it is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_cfg_q <= '0;
            cnt_cfg_q <= CNT_CFG_RST;
            intv_q    <= '0;
            match_q   <= '0;
            ien_q     <= '0;
        end else begin
            if (cnt_cfg_q.restart)
                cnt_cfg_q.restart <= 1'b0;
            if (bus_wr_i) begin
                case (bus_addr_i)
                    AW'(REG_CLK):  clk_cfg_q  <= clk_cfg_t'(bus_wdata_i[CFG_W-1:0]);
                    AW'(REG_CNT):  cnt_cfg_q  <= cnt_cfg_t'(bus_wdata_i[CFG_W-1:0]);
                    AW'(REG_INTV): intv_q     <= bus_wdata_i[CW-1:0];
                    AW'(REG_M0):   match_q[0] <= bus_wdata_i[CW-1:0];
                    AW'(REG_M1):   match_q[1] <= bus_wdata_i[CW-1:0];
                    AW'(REG_M2):   match_q[2] <= bus_wdata_i[CW-1:0];
                    AW'(REG_IEN):  ien_q      <= bus_wdata_i[NEV-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Read mux, zero-extended
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            AW'(REG_CLK):   bus_rdata_o[CFG_W-1:0] = clk_cfg_q;
            AW'(REG_CNT):   bus_rdata_o[CFG_W-1:0] = cnt_cfg_q;
            AW'(REG_COUNT): bus_rdata_o[CW-1:0]    = cnt;
            AW'(REG_INTV):  bus_rdata_o[CW-1:0]    = intv_q;
            AW'(REG_M0):    bus_rdata_o[CW-1:0]    = match_q[0];
            AW'(REG_M1):    bus_rdata_o[CW-1:0]    = match_q[1];
            AW'(REG_M2):    bus_rdata_o[CW-1:0]    = match_q[2];
            AW'(REG_STAT):  bus_rdata_o[NEV-1:0]   = status;
            AW'(REG_IEN):   bus_rdata_o[NEV-1:0]   = ien_q;
            default: ;
        endcase
    end

    pim_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk_i (ext_clk_i),
        .cfg_i     (clk_cfg_q),
        .run_i     (!cnt_cfg_q.halt),
        .restart_i (cnt_cfg_q.restart),
        .tick_o    (tick)
    );

    pim_count_core #(.CW(CW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .restart_i   (cnt_cfg_q.restart),
        .down_i      (cnt_cfg_q.down),
        .intv_mode_i (cnt_cfg_q.intv_mode),
        .match_en_i  (cnt_cfg_q.match_en),
        .wave_dis_i  (cnt_cfg_q.wave_dis),
        .wave_pol_i  (cnt_cfg_q.wave_pol),
        .intv_i      (intv_q),
        .match_i     (match_q),
        .cnt_o       (cnt),
        .ev_o        (ev),
        .wave_o      (wave_o)
    );

    pim_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .rd_clr_i (rd_clr),
        .ien_i    (ien_q),
        .status_o (status),
        .irq_o    (irq_o)
    );

    AST_RESTART_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cfg_q.restart && !(bus_wr_i && bus_addr_i == AW'(REG_CNT)))
        |=> !cnt_cfg_q.restart); // R3

endmodule

// File: tb/pim_timer_tb_top.sv
// Scoreboard bench: register reads push their expected values into a queue, and
// a monitor compares each read at the falling edge. Pin checks are made directly.
module pim_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_CLK = 4'd0, A_CNT = 4'd1, A_COUNT = 4'd2, A_INTV = 4'd3,
                           A_M0 = 4'd4, A_M1 = 4'd5, A_M2 = 4'd6, A_STAT = 4'd7, A_IEN = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wave;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    exp_t item;

    always #(CLK_PERIOD/2) clk = ~clk;

    pim_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk_i   (ext_clk),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .wave_o      (wave),
        .irq_o       (irq)
    );

    function automatic void check(input logic [31:0] act, input logic [31:0] exp,
                                  input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endfunction

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // Driver: queue the expected value, then issue a one-cycle read
    task automatic rd_exp(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        sb_q.push_back('{exp: exp, tag: tag});
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // Start with restart, let n extra clocks pass, then halt: n+1 source edges
    task automatic run_span(input logic [31:0] start, input int n, input logic [31:0] freeze);
        wr_reg(A_CNT, start);
        repeat (n) @(posedge clk);
        wr_reg(A_CNT, freeze);
    endtask

    task automatic pin_check(input logic act, input logic exp, input string tag);
        @(negedge clk);
        check({31'd0, act}, {31'd0, exp}, tag);
    endtask

    // Monitor: compare each read against the head of the scoreboard
    always @(negedge clk) begin
        if (bus_rd) begin
            if (sb_q.size() == 0) begin
                check(bus_rdata, 32'hDEAD_BEEF, "scoreboard underrun");
            end else begin
                item = sb_q.pop_front();
                check(bus_rdata, item.exp, item.tag);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        pin_check(wave, 1'b0, "R1 wave_o after reset");
        pin_check(irq, 1'b0, "R1 irq_o after reset");
        rd_exp(A_CLK, 32'h0, "R1 clock control reset");
        rd_exp(A_CNT, 32'h21, "R1 counter control reset");
        rd_exp(A_COUNT, 32'h0, "R1 count reset");
        rd_exp(A_STAT, 32'h0, "R1 status reset");

        // R2 register set-up, upper bits dropped
        wr_reg(A_INTV, 32'hABCD_0009);
        wr_reg(A_M0, 32'd3);
        wr_reg(A_M1, 32'd7);
        wr_reg(A_M2, 32'd20);
        rd_exp(A_INTV, 32'h9, "R2 interval keeps low half");
        rd_exp(A_M2, 32'd20, "R2 match-2 readback");

        // S1: up, interval 9, 5 steps
        run_span(32'h1A, 4, 32'h0B);
        rd_exp(A_COUNT, 32'd5, "R4 count after 5 bus-clock steps");
        rd_exp(A_STAT, 32'h02, "R8 match-0 flag only");
        pin_check(wave, 1'b0, "R11 polarity 0 low after match-0");
        rd_exp(A_STAT, 32'h0, "R9 status cleared by read");

        // S2: 12 steps, one interval wrap
        run_span(32'h1A, 11, 32'h0B);
        rd_exp(A_COUNT, 32'd2, "R6 up count wraps after interval");
        pin_check(wave, 1'b1, "R11 wrap restores high level");
        pin_check(irq, 1'b0, "R10 no interrupt with enables clear");
        wr_reg(A_IEN, 32'h04);
        pin_check(irq, 1'b1, "R10 interrupt from enabled match-1");
        rd_exp(A_STAT, 32'h07, "R6 interval and match flags");
        pin_check(irq, 1'b0, "R10 interrupt drops after status read");
        wr_reg(A_IEN, 32'h0);

        // S3: prescaler divide by 4, 22 edges
        wr_reg(A_CLK, 32'h03);
        run_span(32'h1A, 21, 32'h0B);
        rd_exp(A_COUNT, 32'd5, "R5 prescaled count");
        rd_exp(A_STAT, 32'h02, "R5 prescaled match-0");
        wr_reg(A_CLK, 32'h00);

        // S4: down interval, match disabled
        run_span(32'h16, 3, 32'h07);
        rd_exp(A_COUNT, 32'd5, "R3 down restart loads interval");
        rd_exp(A_STAT, 32'h0, "R8 no match flags when disabled");
        run_span(32'h16, 12, 32'h07);
        rd_exp(A_COUNT, 32'd6, "R6 down count reloads interval");
        rd_exp(A_STAT, 32'h01, "R6 interval flag on down wrap");

        // S5: down overflow mode, restart self-clear
        wr_reg(A_CNT, 32'h14);
        rd_exp(A_CNT, 32'h04, "R3 restart bit self-clears");
        wr_reg(A_CNT, 32'h05);
        rd_exp(A_COUNT, 32'hFFFC, "R7 down from 0xFFFF");
        rd_exp(A_STAT, 32'h0, "R7 no flag before wrap");

        // S6: up overflow, full range
        run_span(32'h10, 65535, 32'h01);
        rd_exp(A_COUNT, 32'h0, "R7 up wraps past 0xFFFF");
        rd_exp(A_STAT, 32'h10, "R7 overflow flag");

        // S7: polarity 1, then waveform disabled
        run_span(32'h5A, 4, 32'h4B);
        pin_check(wave, 1'b1, "R11 polarity 1 high after match-0");
        wr_reg(A_CNT, 32'h6B);
        pin_check(wave, 1'b0, "R11 output low when disabled");
        rd_exp(A_STAT, 32'h02, "R11 match-0 event recorded");

        // S8: external rising edges
        wr_reg(A_CLK, 32'h20);
        wr_reg(A_CNT, 32'h1A);
        repeat (4) @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 ext_clk = 1'b1;
            repeat (6) @(posedge clk);
            #1 ext_clk = 1'b0;
            repeat (6) @(posedge clk);
        end
        wr_reg(A_CNT, 32'h0B);
        rd_exp(A_COUNT, 32'd3, "R12 rising external edges");

        // S8b: falling edges, input left high
        wr_reg(A_CLK, 32'h60);
        wr_reg(A_CNT, 32'h1A);
        repeat (4) @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 ext_clk = 1'b1;
            repeat (6) @(posedge clk);
            if (i < 2) begin
                #1 ext_clk = 1'b0;
                repeat (6) @(posedge clk);
            end
        end
        wr_reg(A_CNT, 32'h0B);
        rd_exp(A_COUNT, 32'd2, "R12 falling external edges");

        // R2 count register is read-only
        wr_reg(A_COUNT, 32'h1234);
        rd_exp(A_COUNT, 32'd2, "R2 count write ignored");

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule